// File: doc/BRIEF.md
# Conditional Branch and Subroutine Sequencer

This block produces the program counter for a small processor with an 8-bit data path and 16-bit addresses. In each cycle it receives one decoded control-transfer request: sequential advance, jump, call or return. The request comes with a condition selector and an unconditional marker, the current carry, zero, sign and parity flags, the address of the next sequential instruction and a 16-bit absolute target. The program counter register is updated on the next rising clock edge.

A single evaluator applies the same eight flag tests to jumps, calls and returns. A taken call saves the sequential address on an internal last-in-first-out return stack and then loads the target. A taken return loads the program counter from the top of that stack and discards that entry. A call or return whose condition fails does not touch the stack and continues at the sequential address. A call into a full stack, or a return from an empty one, is refused: the stack stays as it was, execution falls through, and a sticky error flag is raised. Instruction fetch, operand decoding, flag generation and memory are handled elsewhere.

Top module: `xfer_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `pc` is 0000h and `taken` and `stack_err` are 0. Reset also empties the return stack.
- R2: Operation code 00 (sequential) loads `seq_addr` into `pc` on the next edge, with `taken` low.
- R3: Operation code 01 (jump) with `uncond` high loads `target_addr` into `pc` on the next edge, with `taken` high.
- R4: When `uncond` is low, `cond_sel` selects the test: 0 carry clear, 1 carry set, 2 zero clear, 3 zero set, 4 parity clear (odd), 5 parity set (even), 6 sign clear (positive), 7 sign set (minus).
- R5: A jump, call or return whose selected condition fails loads `seq_addr` into `pc`, keeps `taken` low and leaves the stack unchanged.
- R6: Operation code 10 (call) whose condition holds pushes `seq_addr` and loads `target_addr` into `pc`, with `taken` high.
- R7: Operation code 11 (return) whose condition holds loads the most recently pushed address into `pc`, removes that entry and raises `taken`.
- R8: The stack holds 8 addresses and returns them in last-in-first-out order across 8 nested calls.
- R9: A call whose condition holds while 8 addresses are stored is refused: the stack is unchanged, `pc` gets `seq_addr`, `taken` stays low and `stack_err` is set.
- R10: A return whose condition holds while the stack is empty is refused: `pc` gets `seq_addr`, `taken` stays low and `stack_err` is set.
- R11: Once set, `stack_err` stays high until reset.
- R12: `taken` is high for exactly one cycle per taken transfer and is never high after a sequential operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xfer_op | input | 2 | 00 sequential, 01 jump, 10 call, 11 return |
| uncond | input | 1 | Transfer ignores the condition |
| cond_sel | input | 3 | Condition selector code |
| flag_carry | input | 1 | Carry flag |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_parity | input | 1 | Parity flag (1 = even parity) |
| seq_addr | input | 16 | Address of the next sequential instruction |
| target_addr | input | 16 | Absolute jump or call target |
| pc | output | 16 | Program counter |
| taken | output | 1 | One-cycle pulse for each taken transfer |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The hardest state to reach from the ports is a full stack with a pending call. Reaching it takes eight consecutive taken calls, each carrying a distinct return address. The bench then issues a ninth call and follows it with eight unconditional returns. The addresses that come back must be the eight saved ones, newest first, which shows the refused push overwrote nothing. Underflow is reached by draining the stack from a fresh reset, and a conditional call that fails is shown not to push by checking the address the next return produces.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic [1:0] {
      XF_SEQ  = 2'b00,
      XF_JUMP = 2'b01,
      XF_CALL = 2'b10,
      XF_RET  = 2'b11
   } xfer_op_e;

   // Flag vector order; the condition code's upper bits index it
   typedef struct packed {
      logic sign;
      logic parity;
      logic zero;
      logic carry;
   } flags_t;

   localparam int COND_W  = 3;
   localparam int N_CONDS = 1 << COND_W;

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval
   import xfer_pkg::*;
#(
   parameter int COND_IMPL = 0   // 0: flag mux plus polarity, 1: decoded test vector
)(
   input  logic [COND_W-1:0] cond_sel,
   input  flags_t            flags,
   output logic              cond_hold
);

   localparam int N_FLAGS = N_CONDS / 2;

   logic [N_FLAGS-1:0] fvec;
   assign fvec = {flags.sign, flags.parity, flags.zero, flags.carry};

   if (COND_IMPL != 0 && COND_IMPL != 1) begin : g_bad_impl
      $error("xfer_cond_eval: COND_IMPL must be 0 or 1");
   end

   if (COND_IMPL == 0) begin : g_mux
      logic picked;
      always_comb begin
         picked = fvec[cond_sel[COND_W-1:1]];
      end
      // bit 0 set: test passes when the flag is 1
      assign cond_hold = cond_sel[0] ? picked : ~picked;
   end else begin : g_vec
      logic [N_CONDS-1:0] tests;
      for (genvar k = 0; k < N_CONDS; k++) begin : g_test
         localparam int  FIDX = k / 2;
         localparam bit  POL  = (k % 2) == 1;
         assign tests[k] = POL ? fvec[FIDX] : ~fvec[FIDX];
      end
      assign cond_hold = tests[cond_sel];
   end

endmodule

// File: rtl/xfer_ret_stack.sv
module xfer_ret_stack #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 8
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] din,
   output logic [ADDR_W-1:0] top,
   output logic              full,
   output logic              empty
);

   localparam int PW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [PW-1:0]     fill;
   logic [IW-1:0]     wr_idx;
   logic [IW-1:0]     rd_idx;
   logic [ADDR_W-1:0] slot [DEPTH];

   assign full   = (fill == PW'(DEPTH));
   assign empty  = (fill == '0);
   assign wr_idx = IW'(fill);
   assign rd_idx = IW'(fill - PW'(1));

   logic do_push, do_pop;
   assign do_push = push & ~full;
   assign do_pop  = pop  & ~empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         fill <= '0;
      end else if (do_push && !do_pop) begin
         fill <= fill + PW'(1);
      end else if (do_pop && !do_push) begin
         fill <= fill - PW'(1);
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && wr_idx == IW'(e)) begin
            slot[e] <= din;
         end
      end
   end

   always_comb begin
      top = '0;
      if (!empty) begin
         top = slot[rd_idx];
      end
   end

endmodule

// File: rtl/xfer_next_pc.sv
module xfer_next_pc #(
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              is_jump,
   input  logic              is_call,
   input  logic              is_ret,
   input  logic              cond_ok,
   input  logic              stk_full,
   input  logic              stk_empty,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [ADDR_W-1:0] target_addr,
   input  logic [ADDR_W-1:0] stk_top,
   output logic              push,
   output logic              pop,
   output logic [ADDR_W-1:0] pc,
   output logic              taken,
   output logic              stack_err
);

   logic jump_go, call_go, ret_go;
   logic call_refused, ret_refused;
   logic [ADDR_W-1:0] pc_nxt;

   always_comb begin
      jump_go      = is_jump & cond_ok;
      call_go      = is_call & cond_ok & ~stk_full;
      ret_go       = is_ret  & cond_ok & ~stk_empty;
      call_refused = is_call & cond_ok &  stk_full;
      ret_refused  = is_ret  & cond_ok &  stk_empty;

      if (jump_go || call_go) begin
         pc_nxt = target_addr;
      end else if (ret_go) begin
         pc_nxt = stk_top;
      end else begin
         pc_nxt = seq_addr;
      end
   end

   assign push = call_go;
   assign pop  = ret_go;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc        <= RESET_PC;
         taken     <= 1'b0;
         stack_err <= 1'b0;
      end else begin
         pc        <= pc_nxt;
         taken     <= jump_go | call_go | ret_go;
         stack_err <= stack_err | call_refused | ret_refused;
      end
   end

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
   import xfer_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int STACK_DEPTH = 8,
   parameter int COND_IMPL   = 0,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        xfer_op,
   input  logic              uncond,
   input  logic [2:0]        cond_sel,
   input  logic              flag_carry,
   input  logic              flag_zero,
   input  logic              flag_sign,
   input  logic              flag_parity,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [ADDR_W-1:0] target_addr,
   output logic [ADDR_W-1:0] pc,
   output logic              taken,
   output logic              stack_err
);

   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
      $error("xfer_sequencer: ADDR_W out of range 2..32");
   end
   if (STACK_DEPTH < 1 || STACK_DEPTH > 256) begin : g_bad_depth
      $error("xfer_sequencer: STACK_DEPTH out of range 1..256");
   end

   xfer_op_e op;
   flags_t   flags;
   logic     hold, cond_ok;
   logic     is_jump, is_call, is_ret;
   logic     push, pop, stk_full, stk_empty;
   logic [ADDR_W-1:0] stk_top;

   assign op      = xfer_op_e'(xfer_op);
   assign flags   = '{sign: flag_sign, parity: flag_parity,
                      zero: flag_zero, carry: flag_carry};
   assign is_jump = (op == XF_JUMP);
   assign is_call = (op == XF_CALL);
   assign is_ret  = (op == XF_RET);
   assign cond_ok = uncond | hold;

   xfer_cond_eval #(
      .COND_IMPL (COND_IMPL)
   ) u_cond (
      .cond_sel  (cond_sel),
      .flags     (flags),
      .cond_hold (hold)
   );

   xfer_ret_stack #(
      .ADDR_W (ADDR_W),
      .DEPTH  (STACK_DEPTH)
   ) u_stack (
      .clk   (clk),
      .rst   (rst),
      .push  (push),
      .pop   (pop),
      .din   (seq_addr),
      .top   (stk_top),
      .full  (stk_full),
      .empty (stk_empty)
   );

   xfer_next_pc #(
      .ADDR_W   (ADDR_W),
      .RESET_PC (RESET_PC)
   ) u_npc (
      .clk         (clk),
      .rst         (rst),
      .is_jump     (is_jump),
      .is_call     (is_call),
      .is_ret      (is_ret),
      .cond_ok     (cond_ok),
      .stk_full    (stk_full),
      .stk_empty   (stk_empty),
      .seq_addr    (seq_addr),
      .target_addr (target_addr),
      .stk_top     (stk_top),
      .push        (push),
      .pop         (pop),
      .pc          (pc),
      .taken       (taken),
      .stack_err   (stack_err)
   );

endmodule

// File: rtl/xfer_sequencer_chk.sv
module xfer_sequencer_chk #(
   parameter int ADDR_W = 16
)(
   input logic              clk,
   input logic              rst,
   input logic [1:0]        xfer_op,
   input logic              uncond,
   input logic              stk_full,
   input logic              stk_empty,
   input logic [ADDR_W-1:0] seq_addr,
   input logic [ADDR_W-1:0] target_addr,
   input logic [ADDR_W-1:0] pc,
   input logic              taken,
   input logic              stack_err
);

   p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
      (xfer_op == 2'b00) |=> (!taken && pc == $past(seq_addr)));

   p_jump_always_r3: assert property (@(posedge clk) disable iff (rst)
      (xfer_op == 2'b01 && uncond) |=> (taken && pc == $past(target_addr)));

   p_untaken_falls_r5: assert property (@(posedge clk) disable iff (rst)
      (xfer_op != 2'b00) |=> (taken || pc == $past(seq_addr)));

   p_call_target_r6: assert property (@(posedge clk) disable iff (rst)
      (xfer_op == 2'b10 && uncond && !stk_full) |=> (taken && pc == $past(target_addr)));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
      (xfer_op == 2'b10 && uncond && stk_full) |=> (!taken && stack_err && $stable(stk_full)));

   p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
      (xfer_op == 2'b11 && uncond && stk_empty) |=> (!taken && stack_err && stk_empty));

   p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      stack_err |=> stack_err);

   p_taken_source_r12: assert property (@(posedge clk) disable iff (rst)
      (xfer_op == 2'b00) |=> !taken);

endmodule

bind xfer_sequencer xfer_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .xfer_op     (xfer_op),
   .uncond      (uncond),
   .stk_full    (stk_full),
   .stk_empty   (stk_empty),
   .seq_addr    (seq_addr),
   .target_addr (target_addr),
   .pc          (pc),
   .taken       (taken),
   .stack_err   (stack_err)
);

// File: tb/sim_xfer_sequencer.sv
module sim_xfer_sequencer;

   localparam logic [1:0] OP_SEQ  = 2'b00;
   localparam logic [1:0] OP_JMP  = 2'b01;
   localparam logic [1:0] OP_CALL = 2'b10;
   localparam logic [1:0] OP_RET  = 2'b11;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  xfer_op = OP_SEQ;
   logic        uncond = 1'b0;
   logic [2:0]  cond_sel = '0;
   logic        flag_carry = 1'b0, flag_zero = 1'b0, flag_sign = 1'b0, flag_parity = 1'b0;
   logic [15:0] seq_addr = '0, target_addr = '0;
   logic [15:0] pc;
   logic        taken, stack_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   xfer_sequencer u0 (
      .clk(clk), .rst(rst), .xfer_op(xfer_op), .uncond(uncond), .cond_sel(cond_sel),
      .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sign(flag_sign),
      .flag_parity(flag_parity), .seq_addr(seq_addr), .target_addr(target_addr),
      .pc(pc), .taken(taken), .stack_err(stack_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // fl = {sign, parity, zero, carry}
   function automatic bit cond_true(input logic [2:0] sel, input logic [3:0] fl);
      case (sel)
         3'd0: return !fl[0];
         3'd1: return  fl[0];
         3'd2: return !fl[1];
         3'd3: return  fl[1];
         3'd4: return !fl[2];
         3'd5: return  fl[2];
         3'd6: return !fl[3];
         default: return fl[3];
      endcase
   endfunction

   // Drive at a falling edge, return at the next falling edge
   task automatic step(input logic [1:0] op, input logic unc, input logic [2:0] sel,
                       input logic [3:0] fl, input logic [15:0] seq, input logic [15:0] tgt);
      xfer_op = op; uncond = unc; cond_sel = sel;
      {flag_sign, flag_parity, flag_zero, flag_carry} = fl;
      seq_addr = seq; target_addr = tgt;
      @(negedge clk);
   endtask

   task automatic do_reset;
      rst = 1'b1;
      xfer_op = OP_SEQ;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "pc in reset", pc, 16'h0000);
      rst = 1'b0;
      chk("R1", "pc after reset", pc, 16'h0000);
      chk("R1", "taken after reset", taken, 0);
      chk("R1", "err after reset", stack_err, 0);
   endtask

   task automatic t_sequential;
      for (int i = 0; i < 4; i++) begin
         step(OP_SEQ, 1'b1, 3'd1, 4'hF, 16'h0040 + 16'(i * 3), 16'hBEEF);
         chk("R2", "pc on sequential", pc, 16'h0040 + 16'(i * 3));
         chk("R12", "taken on sequential", taken, 0);
      end
   endtask

   task automatic t_jump;
      step(OP_JMP, 1'b1, 3'd0, 4'hF, 16'h0101, 16'h8A3C);
      chk("R3", "pc on jump", pc, 16'h8A3C);
      chk("R3", "taken on jump", taken, 1);
      step(OP_SEQ, 1'b0, 3'd0, 4'h0, 16'h8A3D, 16'h0000);
      chk("R12", "taken one cycle", taken, 0);
      chk("R2", "pc after jump", pc, 16'h8A3D);
   endtask

   task automatic t_cond_matrix;
      for (int s = 0; s < 8; s++) begin
         for (int f = 0; f < 16; f++) begin
            logic [15:0] sq, tg;
            bit want;
            sq = 16'h1000 + 16'(s * 16 + f);
            tg = 16'hC000 + 16'(s * 16 + f);
            want = cond_true(3'(s), 4'(f));
            step(OP_JMP, 1'b0, 3'(s), 4'(f), sq, tg);
            chk("R4", $sformatf("taken sel %0d flags %0h", s, f), taken, 32'(want));
            chk(want ? "R4" : "R5", $sformatf("pc sel %0d flags %0h", s, f), pc,
                want ? tg : sq);
         end
      end
   endtask

   task automatic t_call_ret;
      do_reset();
      step(OP_CALL, 1'b1, 3'd0, 4'h0, 16'h0003, 16'h1000);
      chk("R6", "pc on call", pc, 16'h1000);
      chk("R6", "taken on call", taken, 1);
      // carry set test with carry clear: fails, no push
      step(OP_CALL, 1'b0, 3'd1, 4'h0, 16'h1003, 16'h2000);
      chk("R5", "failed call pc", pc, 16'h1003);
      chk("R5", "failed call taken", taken, 0);
      // zero set test with zero clear: return fails
      step(OP_RET, 1'b0, 3'd3, 4'h0, 16'h1004, 16'h0000);
      chk("R5", "failed return pc", pc, 16'h1004);
      // even parity test with parity set: return taken
      step(OP_RET, 1'b0, 3'd5, 4'h4, 16'h1005, 16'h0000);
      chk("R7", "return pc", pc, 16'h0003);
      chk("R7", "return taken", taken, 1);
      step(OP_RET, 1'b1, 3'd0, 4'h0, 16'h0004, 16'h0000);
      chk("R10", "underflow pc", pc, 16'h0004);
      chk("R10", "underflow taken", taken, 0);
      chk("R10", "underflow err", stack_err, 1);
      for (int i = 0; i < 3; i++) begin
         step(OP_SEQ, 1'b0, 3'd0, 4'h0, 16'h0005 + 16'(i), 16'h0000);
         chk("R11", "err stays set", stack_err, 1);
      end
      // a new call still works and the stack is still empty beneath it
      step(OP_CALL, 1'b1, 3'd0, 4'h0, 16'h0009, 16'h3000);
      step(OP_RET, 1'b1, 3'd0, 4'h0, 16'h3001, 16'h0000);
      chk("R10", "stack intact after underflow", pc, 16'h0009);
      do_reset();
   endtask

   task automatic t_nest;
      do_reset();
      for (int i = 0; i < 8; i++) begin
         step(OP_CALL, 1'b1, 3'd0, 4'h0, 16'h0100 + 16'(i), 16'h2000 + 16'(i));
         chk("R8", $sformatf("nested call %0d pc", i), pc, 16'h2000 + 16'(i));
      end
      chk("R9", "err before overflow", stack_err, 0);
      step(OP_CALL, 1'b0, 3'd7, 4'h8, 16'h2008, 16'h5555);
      chk("R9", "overflow pc", pc, 16'h2008);
      chk("R9", "overflow taken", taken, 0);
      chk("R9", "overflow err", stack_err, 1);
      for (int i = 7; i >= 0; i--) begin
         step(OP_RET, 1'b1, 3'd0, 4'h0, 16'hFFFF, 16'h0000);
         chk("R8", $sformatf("unwind %0d pc", i), pc, 16'h0100 + 16'(i));
         chk("R7", $sformatf("unwind %0d taken", i), taken, 1);
      end
      step(OP_RET, 1'b1, 3'd0, 4'h0, 16'h0777, 16'h0000);
      chk("R10", "empty after unwind", pc, 16'h0777);
      do_reset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      t_sequential();
      t_jump();
      t_cond_matrix();
      t_call_ret();
      t_nest();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule